// File: doc/BRIEF.md
# Per-Core Interrupt Mask and Status Controller

This block collects 32 interrupt lines for one processor core and turns them into a single interrupt request. Each line owns one bit in an enable (mask) register and the same bit in a pending (status) register. Software reaches both registers through simple register write/read ports. The request goes high whenever an enabled line has its pending bit set.

A build-time parameter selects one of three pending-bit behaviours:
- **Level:** a pending bit simply mirrors its input, and software writes to status are ignored.
- **Edge:** a rising edge on a line sets a sticky pending bit. Software clears the bit by writing 1 to it.
- **Legacy latched-level:** a high input sets a sticky pending bit. Software clears the bit by writing 0 to it.

Vectoring, nesting and exception entry belong to the core and are not part of this block.

Top module: `pic_ctrl`

## Requirements
- R1: After synchronous reset, the enable register reads all zeros and the request output is low. In the edge and legacy variants, the pending register also reads all zeros.
- R2: A write to the enable register replaces all 32 bits in one cycle, and the new value reads back after that clock edge. Without a write, the enable register holds its value.
- R3: The request output equals the OR over all bits of (pending AND enable), sampled at the previous clock edge. It is therefore one cycle late.
- R4: Edge variant: a low-to-high transition on a line, seen between two consecutive clock edges, sets its pending bit. The bit stays set after the line falls.
- R5: Edge variant: writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged.
- R6: When a hardware set and a software clear reach the same pending bit in the same cycle, the bit ends set.
- R7: Level variant: each pending bit reads as the live level of its line, whatever the enable register holds, and writes to the pending register have no effect.
- R8: Legacy variant: a line sampled high sets its pending bit, which stays set after the line falls. Writing a 0 clears the bit, and writing a 1 leaves it unchanged.
- R9: Edge variant: a line held steadily high does not set its pending bit again after software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Interrupt input lines, synchronous to clk |
| mask_we | input | 1 | Enable-register write strobe |
| mask_wdata | input | 32 | Enable-register write value |
| mask_rdata | output | 32 | Current enable-register value |
| stat_we | input | 1 | Pending-register write strobe |
| stat_wdata | input | 32 | Pending-register write value (clear pattern per variant) |
| stat_rdata | output | 32 | Current pending-register value |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
The assertions check several properties on every cycle:
- the one-cycle relation between pending, enable and the request;
- that a mask write takes effect and that the mask otherwise holds;
- that the level variant mirrors its inputs;
- that a sticky pending bit falls only when the current write pattern clears it.

Other behaviours need a stimulus history, so only the bench scenarios can show them:
- that a set wins over a clear in the same cycle;
- that a line held steadily high does not set its bit again in the edge variant;
- that the legacy variant uses the inverted clear polarity.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int PIC_LINES = 32;

    typedef enum logic [1:0] {
        PIC_LEVEL  = 2'd0,
        PIC_EDGE   = 2'd1,
        PIC_LEGACY = 2'd2
    } pic_variant_e;

    typedef struct packed {
        logic                 we;
        logic [PIC_LINES-1:0] data;
    } pic_wr_t;

    // Bits a software write asks to drop, per variant polarity.
    function automatic logic [PIC_LINES-1:0] clear_bits(pic_variant_e v, pic_wr_t w);
        if (!w.we)            return '0;
        if (v == PIC_EDGE)    return w.data;
        if (v == PIC_LEGACY)  return ~w.data;
        return '0;
    endfunction

    // Hardware set dominates software clear.
    function automatic logic [PIC_LINES-1:0] next_pending(
        logic [PIC_LINES-1:0] cur,
        logic [PIC_LINES-1:0] set,
        logic [PIC_LINES-1:0] clr);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/pic_edge_detect.sv
module pic_edge_detect
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIC_LINES-1:0] lines,
    output logic [PIC_LINES-1:0] rise
);
    logic [PIC_LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
endmodule

// File: rtl/pic_mask_reg.sv
module pic_mask_reg
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  pic_wr_t              wr,
    output logic [PIC_LINES-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)        mask <= '0;
        else if (wr.we) mask <= wr.data;
    end
endmodule

// File: rtl/pic_status_bank.sv
module pic_status_bank
    import pic_pkg::*;
#(
    parameter pic_variant_e VARIANT = PIC_EDGE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIC_LINES-1:0] lines,
    input  pic_wr_t              wr,
    output logic [PIC_LINES-1:0] pending
);
    generate
        if (VARIANT == PIC_LEVEL) begin : g_level
            assign pending = lines;
        end else begin : g_latched
            logic [PIC_LINES-1:0] set_vec;
            logic [PIC_LINES-1:0] clr_vec;
            logic [PIC_LINES-1:0] pend_q;

            if (VARIANT == PIC_EDGE) begin : g_edge
                pic_edge_detect u_edge (
                    .clk   (clk),
                    .rst   (rst),
                    .lines (lines),
                    .rise  (set_vec)
                );
            end else begin : g_lvl_latch
                assign set_vec = lines;
            end

            assign clr_vec = clear_bits(VARIANT, wr);

            always_ff @(posedge clk) begin
                if (rst) pend_q <= '0;
                else     pend_q <= next_pending(pend_q, set_vec, clr_vec);
            end

            assign pending = pend_q;
        end
    endgenerate
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter pic_variant_e VARIANT = PIC_EDGE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIC_LINES-1:0] irq_lines,
    input  logic                 mask_we,
    input  logic [PIC_LINES-1:0] mask_wdata,
    output logic [PIC_LINES-1:0] mask_rdata,
    input  logic                 stat_we,
    input  logic [PIC_LINES-1:0] stat_wdata,
    output logic [PIC_LINES-1:0] stat_rdata,
    output logic                 irq_req
);
    pic_wr_t mask_wr;
    pic_wr_t stat_wr;
    logic [PIC_LINES-1:0] enabled;

    assign mask_wr = '{we: mask_we, data: mask_wdata};
    assign stat_wr = '{we: stat_we, data: stat_wdata};

    pic_mask_reg u_mask (
        .clk  (clk),
        .rst  (rst),
        .wr   (mask_wr),
        .mask (mask_rdata)
    );

    pic_status_bank #(.VARIANT(VARIANT)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .lines   (irq_lines),
        .wr      (stat_wr),
        .pending (stat_rdata)
    );

    assign enabled = stat_rdata & mask_rdata;

    always_ff @(posedge clk) begin
        if (rst) irq_req <= 1'b0;
        else     irq_req <= |enabled;
    end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
    import pic_pkg::*;
#(
    parameter pic_variant_e VARIANT = PIC_EDGE
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PIC_LINES-1:0] irq_lines,
    input logic                 mask_we,
    input logic [PIC_LINES-1:0] mask_wdata,
    input logic [PIC_LINES-1:0] mask_rdata,
    input logic                 stat_we,
    input logic [PIC_LINES-1:0] stat_wdata,
    input logic [PIC_LINES-1:0] stat_rdata,
    input logic                 irq_req
);
    localparam logic IS_LEVEL  = (VARIANT == PIC_LEVEL);
    localparam logic IS_LEGACY = (VARIANT == PIC_LEGACY);

    logic [PIC_LINES-1:0] clr_sel;
    always_comb begin
        if (!stat_we)       clr_sel = '0;
        else if (IS_LEGACY) clr_sel = ~stat_wdata;
        else                clr_sel = stat_wdata;
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (mask_rdata == '0 && !irq_req));

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> mask_rdata == $past(mask_wdata));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_rdata));

    // R3
    req_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_req == $past(|(stat_rdata & mask_rdata)));

    // R7
    level_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        IS_LEVEL |-> stat_rdata == irq_lines);

    // R4
    sticky_pend_chk: assert property (@(posedge clk) disable iff (rst)
        !IS_LEVEL |=> (($past(stat_rdata) & ~$past(clr_sel) & ~stat_rdata) == '0));
endmodule

bind pic_ctrl pic_ctrl_chk #(.VARIANT(VARIANT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_lines  (irq_lines),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .mask_rdata (mask_rdata),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .stat_rdata (stat_rdata),
    .irq_req    (irq_req)
);

// File: tb/pic_ctrl_test.sv
module pic_ctrl_test;
    import pic_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_lines = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        stat_we = 1'b0;
    logic [31:0] stat_wdata = '0;

    logic [31:0] e_mask, e_stat, v_mask, v_stat, g_mask, g_stat;
    logic        e_req, v_req, g_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pic_ctrl #(.VARIANT(PIC_EDGE)) uut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(e_mask),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(e_stat),
        .irq_req(e_req));

    pic_ctrl #(.VARIANT(PIC_LEVEL)) uut_lvl (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(v_mask),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(v_stat),
        .irq_req(v_req));

    pic_ctrl #(.VARIANT(PIC_LEGACY)) uut_leg (
        .clk(clk), .rst(rst), .irq_lines(irq_lines),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(g_mask),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(g_stat),
        .irq_req(g_req));

    // {lines, stat_we, stat_wdata, expected edge-variant pending}
    localparam int NV = 11;
    localparam logic [96:0] VEC [NV] = '{
        {32'h0000_0001, 1'b0, 32'h0000_0000, 32'h0000_0001}, // R4 rise sets
        {32'h0000_0000, 1'b0, 32'h0000_0000, 32'h0000_0001}, // R4 held
        {32'h0000_0000, 1'b1, 32'h0000_0000, 32'h0000_0001}, // R5 write 0 keeps
        {32'h0000_0000, 1'b1, 32'h0000_0001, 32'h0000_0000}, // R5 write 1 clears
        {32'h0000_0102, 1'b0, 32'h0000_0000, 32'h0000_0102}, // R4 two lines
        {32'h0000_0102, 1'b1, 32'h0000_0102, 32'h0000_0000}, // R9 steady high, cleared
        {32'h0000_0100, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R9 no re-set
        {32'h0000_0104, 1'b1, 32'h0000_0004, 32'h0000_0004}, // R6 set beats clear
        {32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}, // R5 clear all
        {32'h0000_0100, 1'b0, 32'h0000_0000, 32'h0000_0100}, // R4 masked line
        {32'h0000_0000, 1'b0, 32'h0000_0000, 32'h0000_0100}  // R3 masked => no req
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        logic [31:0] prev_stat;
        logic [31:0] cur_mask;

        tick; tick;
        // R1 reset state
        check32("R1 edge mask", e_mask, 32'h0);
        check32("R1 edge pending", e_stat, 32'h0);
        check1("R1 edge req", e_req, 1'b0);
        check32("R1 legacy pending", g_stat, 32'h0);
        check1("R1 level req", v_req, 1'b0);

        rst = 1'b0;
        // R2 mask write and hold
        mask_we = 1'b1; mask_wdata = 32'hA5A5_0F0F;
        tick;
        mask_we = 1'b0; mask_wdata = 32'h1234_5678;
        check32("R2 mask load", e_mask, 32'hA5A5_0F0F);
        tick;
        check32("R2 mask hold", e_mask, 32'hA5A5_0F0F);
        mask_we = 1'b1; mask_wdata = 32'h0000_00FF;
        tick;
        mask_we = 1'b0;
        cur_mask = 32'h0000_00FF;
        check32("R2 mask reload", e_mask, cur_mask);

        // vector walk on the edge variant
        prev_stat = 32'h0;
        for (int i = 0; i < NV; i++) begin
            irq_lines  = VEC[i][96:65];
            stat_we    = VEC[i][64];
            stat_wdata = VEC[i][63:32];
            tick;
            check1("R3 edge req", e_req, |(prev_stat & cur_mask));
            check32("R4/R5/R6/R9 edge pending", e_stat, VEC[i][31:0]);
            prev_stat = VEC[i][31:0];
        end
        stat_we = 1'b0;

        // R7 level variant: live, mask-independent, writes ignored
        irq_lines = 32'h0000_0005;
        stat_we = 1'b1; stat_wdata = 32'hFFFF_FFFF;
        tick;
        check32("R7 level mirrors", v_stat, 32'h0000_0005);
        stat_wdata = 32'h0;
        tick;
        stat_we = 1'b0;
        check32("R7 level write ignored", v_stat, 32'h0000_0005);
        check1("R3 level req", v_req, 1'b1);
        mask_we = 1'b1; mask_wdata = 32'h0;
        tick;
        mask_we = 1'b0;
        check32("R7 level ignores mask", v_stat, 32'h0000_0005);
        tick;
        check1("R3 level req masked", v_req, 1'b0);
        irq_lines = 32'h0;
        #1;
        check32("R7 level follows fall", v_stat, 32'h0);

        // R8 legacy variant
        stat_we = 1'b1; stat_wdata = 32'h0;
        tick;
        stat_we = 1'b0;
        check32("R8 legacy cleared", g_stat, 32'h0);
        irq_lines = 32'h0000_0008;
        tick;
        irq_lines = 32'h0;
        check32("R8 legacy latch", g_stat, 32'h0000_0008);
        tick;
        check32("R8 legacy held", g_stat, 32'h0000_0008);
        stat_we = 1'b1; stat_wdata = 32'hFFFF_FFFF;
        tick;
        check32("R8 legacy write 1 keeps", g_stat, 32'h0000_0008);
        stat_wdata = 32'hFFFF_FFF7;
        tick;
        stat_we = 1'b0;
        check32("R8 legacy write 0 clears", g_stat, 32'h0);
        irq_lines = 32'h0000_0010;
        stat_we = 1'b1; stat_wdata = 32'h0;
        tick;
        stat_we = 1'b0; irq_lines = 32'h0;
        check32("R6 legacy set beats clear", g_stat, 32'h0000_0010);

        // R1 reset mid-run
        rst = 1'b1;
        tick;
        rst = 1'b0;
        check32("R1 legacy pending after reset", g_stat, 32'h0);
        check32("R1 mask after reset", g_mask, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule